// File: doc/BRIEF.md
# Flash Embedded-Operation Status Bit Generator

This block produces the word a NOR flash returns to the host when it is read while an internal program or erase runs. The host reads the device again and again. Two toggle bits show, from one read to the next, whether an operation is still running. They also show whether an erase is active or suspended, and which sectors are marked for erase. A failure flag shows that the internal pulse count ran past its limit.

The operating mode, the per-sector erase mask and the timeout flag come in as plain inputs. Each read strobe carries a sector number, decoded from the read address, and the current array word. One clock after the strobe, the block presents either a status word or the array word on its output. The output then holds until the next strobe.

Top module: `flash_status_gen`

## Requirements
- R1: `op_mode` is encoded as 0 idle, 1 programming, 2 erasing, 3 erase suspended and 4 programming during erase suspend; codes 5 to 7 act as idle. In idle, a strobed read puts `array_q` on `rd_data` one clock later, and the toggle state and the failure flag clear, so the first toggling read of the next operation shows bit 6 = 1.
- R2: While programming, each strobed read inverts bit 6 of the status word, and bit 2 keeps its value.
- R3: While erasing, a strobed read whose sector is set in `erase_sel` inverts both bit 6 and bit 2.
- R4: While erasing, a strobed read in a sector not set in `erase_sel` inverts bit 6, and bit 2 keeps its value.
- R5: While erase is suspended, a strobed read in a selected sector keeps bit 6 and inverts bit 2.
- R6: While erase is suspended, a strobed read in a non-selected sector returns `array_q` and changes neither toggle.
- R7: While programming during erase suspend, each strobed read inverts bit 6, and bit 2 reads 0. The bit 2 toggle state is kept for the return to suspend.
- R8: Bit 5 becomes 1 from the clock after `pulse_limit` is high in mode 1, 2 or 4. It stays 1 until idle or reset. `pulse_limit` has no effect in mode 3.
- R9: Without a strobe, neither toggle changes and `rd_data` keeps its value.
- R10: An active-low `rst_n` clears `rd_data`, both toggles and the failure flag at once.
- R11: A status word carries the bit 6 toggle in bit 6, the failure flag in bit 5 and the bit 2 toggle in bit 2. Every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| op_mode | input | 3 | operating mode (see R1) |
| erase_sel | input | NSECT | one bit per sector, 1 = marked for erase |
| rd_sect | input | SECT_W | sector decoded from the read address |
| rd_stb | input | 1 | read strobe, one per host read |
| array_q | input | DATA_W | array word at the read address |
| pulse_limit | input | 1 | internal pulse count exceeded |
| rd_data | output | DATA_W | word returned to the host |

## Verification
The hardest state to reach is toggle history carried across mode changes that never pass through idle. Examples are an erase that is suspended, used for a programming run, resumed, and then finds its failure flag raised. Directed sequences walk erase, suspend, programming in suspend, suspend and erase again, checking bit continuity at each step. Random runs change mode only rarely, and seldom through idle, so long histories build up before they are cleared.

// File: rtl/flash_status_gen.sv
`timescale 1ns/100ps
module flash_status_gen #(
  parameter int DATA_W = 16,
  parameter int NSECT  = 8,
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_mode,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] array_q,
  input  logic              pulse_limit,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [2:0] M_PROG = 3'd1, M_ERASE = 3'd2, M_SUSP = 3'd3, M_PSUSP = 3'd4;

  logic tog6, tog2, fail;
  logic idle, sel, hit6, hit2, show_array;
  logic [DATA_W-1:0] status_w;

  assign idle = (op_mode == 3'd0) || (op_mode > M_PSUSP);
  assign sel  = erase_sel[rd_sect];
  assign hit6 = rd_stb && (op_mode == M_PROG || op_mode == M_ERASE || op_mode == M_PSUSP);
  assign hit2 = rd_stb && sel && (op_mode == M_ERASE || op_mode == M_SUSP);
  assign show_array = idle || (op_mode == M_SUSP && !sel);

  always_comb begin
    status_w    = '0;
    status_w[6] = tog6 ^ hit6;
    status_w[5] = fail;
    status_w[2] = (op_mode == M_PSUSP) ? 1'b0 : (tog2 ^ hit2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog6 <= 1'b0; tog2 <= 1'b0; fail <= 1'b0; rd_data <= '0;
    end else begin
      if (idle) begin
        tog6 <= 1'b0; tog2 <= 1'b0; fail <= 1'b0;
      end else begin
        tog6 <= tog6 ^ hit6;
        tog2 <= tog2 ^ hit2;
        if (pulse_limit && op_mode != M_SUSP) fail <= 1'b1;
      end
      if (rd_stb) rd_data <= show_array ? array_q : status_w;
    end
  end

  // R1
  idle_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && idle) |=> (rd_data == $past(array_q)) && !tog6 && !tog2 && !fail);
  // R2
  prog_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_mode == M_PROG) |=> (tog6 != $past(tog6)) && (tog2 == $past(tog2)));
  // R5
  susp_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_mode == M_SUSP && sel) |=> (tog6 == $past(tog6)) && (tog2 != $past(tog2)));
  // R6
  susp_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_mode == M_SUSP && !sel) |=> (rd_data == $past(array_q)) && $stable(tog6) && $stable(tog2));
  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !idle) |=> fail);
  // R9
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !idle) |=> $stable(tog6) && $stable(tog2) && $stable(rd_data));
endmodule

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/100ps
module sim_flash_status_gen;
  localparam int DW = 16, NS = 8, SW = 3;
  logic clk = 1'b0, rst_n = 1'b0, rd_stb = 1'b0, pulse_limit = 1'b0;
  logic [2:0] op_mode = 3'd0;
  logic [NS-1:0] erase_sel = '0;
  logic [SW-1:0] rd_sect = '0;
  logic [DW-1:0] array_q = '0, rd_data;
  int checks = 0, errors = 0;
  logic m6 = 0, m2 = 0, mf = 0;
  logic [DW-1:0] mq = '0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .NSECT(NS)) u0 (.clk, .rst_n, .op_mode, .erase_sel,
    .rd_sect, .rd_stb, .array_q, .pulse_limit, .rd_data);

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] m, logic s, logic stb);
    if (!stb) return "R9";
    case (m)
      3'd1: return "R2";
      3'd2: return s ? "R3" : "R4";
      3'd3: return s ? "R5" : "R6";
      3'd4: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic step();
    logic idle, s, n6, n2;
    logic [DW-1:0] w;
    string tag;
    idle = (op_mode == 0) || (op_mode > 4);
    s = erase_sel[rd_sect];
    tag = pulse_limit ? "R8" : tag_of(op_mode, s, rd_stb);
    n6 = m6 ^ (rd_stb && (op_mode == 1 || op_mode == 2 || op_mode == 4));
    n2 = m2 ^ (rd_stb && s && (op_mode == 2 || op_mode == 3));
    w = '0; w[6] = n6; w[5] = mf; w[2] = (op_mode == 4) ? 1'b0 : n2;
    if (rd_stb) mq = (idle || (op_mode == 3 && !s)) ? array_q : w;
    if (idle) begin m6 = 0; m2 = 0; mf = 0; end
    else begin m6 = n6; m2 = n2; if (pulse_limit && op_mode != 3) mf = 1; end
    @(posedge clk); @(negedge clk);
    check(tag, rd_data, mq);
  endtask

  task automatic rd(logic [2:0] m, logic [SW-1:0] sc, logic [DW-1:0] a);
    op_mode = m; rd_sect = sc; array_q = a; rd_stb = 1; step(); rd_stb = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; #1;
    m6 = 0; m2 = 0; mf = 0; mq = '0;
    @(negedge clk); check("R10", rd_data, '0);
    rst_n = 1;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    check("R10", rd_data, '0);
    rst_n = 1;
    erase_sel = 8'b0010_0100;
    // R1 idle returns array
    rd(0, 3, 16'hA5C3); rd(7, 1, 16'h1234);
    // R2 programming: bit6 toggles, first read shows 1
    rd(1, 0, 16'hFFFF); check("R2", rd_data & 16'h0040, 16'h0040); check("R11", rd_data & ~16'h0064, 16'h0);
    rd(1, 5, 16'hFFFF); rd(1, 2, 16'h0);
    // R9 hold without strobe
    repeat (3) step();
    // R3/R4 erase
    rd(0, 0, 16'h0F0F);
    rd(2, 2, 16'h0); rd(2, 5, 16'h0); rd(2, 0, 16'h0); rd(2, 7, 16'h0);
    // R5/R6 suspend
    rd(3, 2, 16'h0); rd(3, 5, 16'h0); rd(3, 1, 16'hBEEF); rd(3, 6, 16'hCAFE);
    // R7 programming in suspend, bit2 reads 0
    rd(4, 2, 16'h0); check("R7", rd_data & 16'h0004, 16'h0); rd(4, 3, 16'h0);
    rd(3, 5, 16'h0); rd(2, 2, 16'h0);
    // R8 failure flag
    pulse_limit = 1; op_mode = 2; step(); pulse_limit = 0;
    rd(2, 1, 16'h0); check("R8", rd_data & 16'h0020, 16'h0020);
    pulse_limit = 1; rd(3, 5, 16'h0); pulse_limit = 0; rd(4, 0, 16'h0);
    rd(0, 0, 16'h7777); rd(3, 2, 16'h0); pulse_limit = 1; rd(3, 2, 16'h0); pulse_limit = 0;
    rd(3, 5, 16'h0); check("R8", rd_data & 16'h0020, 16'h0);
    // R10 reset mid operation
    rd(1, 0, 16'h0); pulse_limit = 1; step(); pulse_limit = 0;
    do_reset(); op_mode = 0; step();
    // random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) begin
        op_mode = 3'($urandom_range(7));
        if (op_mode == 0) erase_sel = NS'($urandom);
      end
      rd_stb = ($urandom_range(1) == 1);
      rd_sect = SW'($urandom);
      array_q = DW'($urandom);
      pulse_limit = ($urandom_range(59) == 0);
      step();
    end
    rd_stb = 0; pulse_limit = 0;
    finish_up();
  end
endmodule